// File: doc/BRIEF.md
# Shared Cache-Maintenance Command Front-End

This block is the register front-end through which several CPUs hand cache maintenance commands to a single downstream executor. Every bus access carries the ID of the CPU making it. The mode, address and size registers are shared by all CPUs. A hardware lock makes sure that only one CPU builds an entry at a time. Failure and completion flags are kept separately for each CPU, so each CPU sees only the results of its own requests.

A CPU builds an entry by writing the mode register. For a range operation it then also writes the address and size registers. It then reads its registration-status register. That read does three things: it releases the lock, it pushes the entry into an in-order FIFO if the entry is complete and the FIFO has room, and it reports why the entry was refused if it was not pushed. The front-end hands entries to the executor one at a time. It does not hand out the next entry until the executor pulses completion for the current one. A separate primitive register requests buffer drain and prefetch-buffer flush pulses. A read of the primitive register is held in wait state until every queued operation has finished.

Top module: `cmq_frontend`

## Requirements
- R1: After reset nobody holds the lock, `cmd_valid` is 0, and every status and primitive read returns 0.
- R2: The first mode write (offset 0x248) by a CPU while the lock is free gives that CPU the lock. While the lock is held, mode, address (0x24C) and size (0x250) writes from any other CPU leave the registers unchanged. Such a write sets bit 0 in that CPU's registration status (0x25C).
- R3: The lock owner's read of registration status releases the lock in every case, and another CPU may then take it.
- R4: The mode word holds the operation in bits 3:0, the notify enable in bit 15 and the scope in bits 18:17, where 1 means whole cache and any other value means address range. A whole-cache entry needs only the mode write. A range entry also needs address and size writes made after that mode write. An owner read of an incomplete entry returns bit 0 set and queues nothing. An owner read of a complete entry returns 0 and queues the entry.
- R5: If the FIFO is full when the owner reads a complete entry, the read returns bit 1 set and nothing is queued.
- R6: Registration-status bit 0 is sticky and held per CPU. It is cleared by that CPU's own registration-status read.
- R7: Entries are issued one at a time in arrival order on `cmd_*`. No new entry is issued until `op_done` has been seen for the one in flight. A whole-cache entry is issued with address and size driven as 0.
- R8: Queue status (0x260) bit 2 is set for the issuing CPU only, when a notify-enabled entry completes. Writing 1 to bit 2 clears it. Writing 0 there, or writing from another CPU, leaves it unchanged.
- R9: In queue status, bit 1 shows that this CPU's entry is executing now. Bit 0 shows that this CPU has entries queued or executing.
- R10: Writing 0x8 to the primitive register (0x244) pulses `drain_req` for one cycle. Writing 0x9 pulses `pf_flush_req`. Other codes pulse neither. A read returns the last code written (bits 3:0).
- R11: A read of the primitive register holds `req_ready` low while any entry is queued or executing. The read completes once the queue has drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cpu | input | CPU_W | ID of the requesting CPU |
| req_addr | input | 12 | Register offset |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Access accepted this cycle (low = wait state) |
| rsp_rdata | output | 32 | Read data, valid with an accepted read |
| cmd_valid | output | 1 | Entry offered to the executor |
| cmd_ready | input | 1 | Executor takes the entry |
| cmd_scope | output | 2 | Entry scope |
| cmd_op | output | 4 | Entry operation |
| cmd_addr | output | AW | Entry start address |
| cmd_size | output | AW | Entry size |
| cmd_cpu | output | CPU_W | Issuing CPU |
| cmd_notify | output | 1 | Completion notify requested |
| op_done | input | 1 | Executor finished the entry in flight |
| drain_req | output | 1 | Buffer drain request pulse |
| pf_flush_req | output | 1 | Prefetch-buffer flush pulse |

## Verification
Registration is tried under contention. A foreign mode write and a foreign address write arrive during ownership; this separates correct rejection of the foreign CPU from wrongly taking over the lock. Entries are then built with a range scope and with a whole-cache scope, and one range entry is left without its address. These cases separate the completeness rule for each scope. Filling the FIFO to depth and posting one entry more separates the queue-full code from the incomplete-entry code. Mixed notify and non-notify entries from different CPUs are run with the executor held off. This shows strict ordering, per-CPU status attribution, and end-flag clearing by write-one only.

// File: rtl/cmq_pkg.sv
package cmq_pkg;

  localparam int OFFS_W = 12;

  localparam logic [OFFS_W-1:0] OFF_PRIM = 12'h244;
  localparam logic [OFFS_W-1:0] OFF_MODE = 12'h248;
  localparam logic [OFFS_W-1:0] OFF_ADDR = 12'h24C;
  localparam logic [OFFS_W-1:0] OFF_SIZE = 12'h250;
  localparam logic [OFFS_W-1:0] OFF_SCE  = 12'h25C;
  localparam logic [OFFS_W-1:0] OFF_QST  = 12'h260;

  localparam logic [31:0] PRIM_DRAIN   = 32'h8;
  localparam logic [31:0] PRIM_PFFLUSH = 32'h9;

  localparam logic [1:0] SCOPE_ALL = 2'd1;

  function automatic logic [3:0] mode_op(input logic [31:0] m);
    return m[3:0];
  endfunction

  function automatic logic mode_notify(input logic [31:0] m);
    return m[15];
  endfunction

  function automatic logic [1:0] mode_scope(input logic [31:0] m);
    return m[18:17];
  endfunction

  // whole-cache scope needs nothing beyond the mode; range needs addr and size
  function automatic logic entry_complete(input logic [31:0] m,
                                          input logic got_addr,
                                          input logic got_size);
    return (mode_scope(m) == SCOPE_ALL) || (got_addr && got_size);
  endfunction

endpackage

// File: rtl/cmq_fifo.sv
module cmq_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_next(wr_ptr);
      if (pop)  rd_ptr <= ptr_next(rd_ptr);
      if (push && !pop)      count <= count + CW'(1);
      else if (pop && !push) count <= count - CW'(1);
    end
  end

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/cmq_lock.sv
module cmq_lock
  import cmq_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int CPU_W = 2,
  parameter int AW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_mode,
  input  logic             wr_addr,
  input  logic             wr_size,
  input  logic             rd_sce,
  input  logic [CPU_W-1:0] acc_cpu,
  input  logic [31:0]      wdata,
  input  logic             q_full,
  output logic             owner_valid,
  output logic [CPU_W-1:0] owner_cpu,
  output logic [31:0]      mode_q,
  output logic [AW-1:0]    addr_q,
  output logic [AW-1:0]    size_q,
  output logic             enq_fire,
  output logic             release_own,
  output logic [1:0]       sce_rdata
);
  logic            got_addr, got_size;
  logic [NCPU-1:0] other_fail;
  logic            is_owner, complete;

  assign is_owner    = owner_valid && (owner_cpu == acc_cpu);
  assign complete    = entry_complete(mode_q, got_addr, got_size);
  assign release_own = rd_sce && is_owner;
  assign enq_fire    = release_own && complete && !q_full;
  assign sce_rdata   = {release_own && complete && q_full,
                        other_fail[acc_cpu] | (release_own && !complete)};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner_valid <= 1'b0;
      owner_cpu   <= '0;
      mode_q      <= '0;
      addr_q      <= '0;
      size_q      <= '0;
      got_addr    <= 1'b0;
      got_size    <= 1'b0;
      other_fail  <= '0;
    end else begin
      if (wr_mode) begin
        if (!owner_valid || is_owner) begin
          owner_valid <= 1'b1;
          owner_cpu   <= acc_cpu;
          mode_q      <= wdata;
          got_addr    <= 1'b0;
          got_size    <= 1'b0;
        end else begin
          other_fail[acc_cpu] <= 1'b1;
        end
      end
      if (wr_addr) begin
        if (is_owner) begin
          addr_q   <= wdata[AW-1:0];
          got_addr <= 1'b1;
        end else begin
          other_fail[acc_cpu] <= 1'b1;
        end
      end
      if (wr_size) begin
        if (is_owner) begin
          size_q   <= wdata[AW-1:0];
          got_size <= 1'b1;
        end else begin
          other_fail[acc_cpu] <= 1'b1;
        end
      end
      if (rd_sce) begin
        other_fail[acc_cpu] <= 1'b0;
        if (is_owner) owner_valid <= 1'b0;
      end
    end
  end

  assert_lock_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_valid && !release_own) |=> (owner_valid && owner_cpu == $past(owner_cpu)));
  assert_enq_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    enq_fire |=> !owner_valid);

endmodule

// File: rtl/cmq_tracker.sv
module cmq_tracker #(
  parameter int NCPU   = 4,
  parameter int CPU_W  = 2,
  parameter int QDEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic [CPU_W-1:0] issue_cpu,
  input  logic             issue_notify,
  input  logic             enq,
  input  logic [CPU_W-1:0] enq_cpu,
  input  logic             op_done,
  input  logic [NCPU-1:0]  ef_clr,
  output logic             busy,
  output logic [CPU_W-1:0] run_cpu,
  output logic             done_fire,
  output logic [NCPU-1:0]  ef_q,
  output logic [NCPU-1:0]  pend_nz
);
  localparam int PCW = $clog2(QDEPTH + 2);

  logic run_notify;

  assign done_fire = op_done && busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      run_cpu    <= '0;
      run_notify <= 1'b0;
    end else if (issue) begin
      busy       <= 1'b1;
      run_cpu    <= issue_cpu;
      run_notify <= issue_notify;
    end else if (done_fire) begin
      busy <= 1'b0;
    end
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic [PCW-1:0] pend;
    logic inc, dec, set_ef;

    assign inc    = enq && (enq_cpu == CPU_W'(c));
    assign dec    = done_fire && (run_cpu == CPU_W'(c));
    assign set_ef = dec && run_notify;
    assign pend_nz[c] = (pend != '0);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend    <= '0;
        ef_q[c] <= 1'b0;
      end else begin
        if (inc && !dec)      pend <= pend + PCW'(1);
        else if (dec && !inc) pend <= pend - PCW'(1);
        if (set_ef)         ef_q[c] <= 1'b1;
        else if (ef_clr[c]) ef_q[c] <= 1'b0;
      end
    end

    assert_ef_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      set_ef |=> ef_q[c]);
  end

  assert_single_issue_R7: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> !busy);

endmodule

// File: rtl/cmq_frontend.sv
module cmq_frontend
  import cmq_pkg::*;
#(
  parameter int NCPU   = 4,
  parameter int AW     = 32,
  parameter int QDEPTH = 4,
  localparam int CPU_W = $clog2(NCPU)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [CPU_W-1:0] req_cpu,
  input  logic [11:0]      req_addr,
  input  logic [31:0]      req_wdata,
  output logic             req_ready,
  output logic [31:0]      rsp_rdata,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [1:0]       cmd_scope,
  output logic [3:0]       cmd_op,
  output logic [AW-1:0]    cmd_addr,
  output logic [AW-1:0]    cmd_size,
  output logic [CPU_W-1:0] cmd_cpu,
  output logic             cmd_notify,
  input  logic             op_done,
  output logic             drain_req,
  output logic             pf_flush_req
);
  localparam int ENT_W = 2 + 4 + 1 + CPU_W + 2 * AW;

  logic acc, acc_wr, acc_rd, prim_rd_req, q_idle;
  logic owner_valid, enq_fire, release_own;
  logic [CPU_W-1:0] owner_cpu;
  logic [31:0] mode_q;
  logic [AW-1:0] addr_q, size_q;
  logic [1:0] sce_rdata;
  logic fifo_empty, fifo_full, pop;
  logic [ENT_W-1:0] ent_in, ent_out;
  logic busy, done_fire;
  logic [CPU_W-1:0] run_cpu;
  logic [NCPU-1:0] ef_q, pend_nz, ef_clr;
  logic [3:0] prim_q;
  logic is_all;

  assign prim_rd_req = req_valid && !req_write && (req_addr == OFF_PRIM);
  assign q_idle      = fifo_empty && !busy;
  assign req_ready   = !(prim_rd_req && !q_idle);
  assign acc         = req_valid && req_ready;
  assign acc_wr      = acc && req_write;
  assign acc_rd      = acc && !req_write;

  cmq_lock #(.NCPU(NCPU), .CPU_W(CPU_W), .AW(AW)) u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_mode    (acc_wr && req_addr == OFF_MODE),
    .wr_addr    (acc_wr && req_addr == OFF_ADDR),
    .wr_size    (acc_wr && req_addr == OFF_SIZE),
    .rd_sce     (acc_rd && req_addr == OFF_SCE),
    .acc_cpu    (req_cpu),
    .wdata      (req_wdata),
    .q_full     (fifo_full),
    .owner_valid(owner_valid),
    .owner_cpu  (owner_cpu),
    .mode_q     (mode_q),
    .addr_q     (addr_q),
    .size_q     (size_q),
    .enq_fire   (enq_fire),
    .release_own(release_own),
    .sce_rdata  (sce_rdata)
  );

  assign is_all = (mode_scope(mode_q) == SCOPE_ALL);
  assign ent_in = {mode_scope(mode_q), mode_op(mode_q), mode_notify(mode_q), owner_cpu,
                   is_all ? {AW{1'b0}} : addr_q,
                   is_all ? {AW{1'b0}} : size_q};

  cmq_fifo #(.WIDTH(ENT_W), .DEPTH(QDEPTH)) u_fifo (
    .clk  (clk),
    .rst_n(rst_n),
    .push (enq_fire),
    .din  (ent_in),
    .pop  (pop),
    .dout (ent_out),
    .empty(fifo_empty),
    .full (fifo_full)
  );

  assign cmd_valid = !fifo_empty && !busy;
  assign pop       = cmd_valid && cmd_ready;
  assign {cmd_scope, cmd_op, cmd_notify, cmd_cpu, cmd_addr, cmd_size} = ent_out;

  for (genvar c = 0; c < NCPU; c++) begin : g_clr
    assign ef_clr[c] = acc_wr && (req_addr == OFF_QST) && (req_cpu == CPU_W'(c)) && req_wdata[2];
  end

  cmq_tracker #(.NCPU(NCPU), .CPU_W(CPU_W), .QDEPTH(QDEPTH)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue       (pop),
    .issue_cpu   (cmd_cpu),
    .issue_notify(cmd_notify),
    .enq         (enq_fire),
    .enq_cpu     (owner_cpu),
    .op_done     (op_done),
    .ef_clr      (ef_clr),
    .busy        (busy),
    .run_cpu     (run_cpu),
    .done_fire   (done_fire),
    .ef_q        (ef_q),
    .pend_nz     (pend_nz)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prim_q       <= '0;
      drain_req    <= 1'b0;
      pf_flush_req <= 1'b0;
    end else begin
      drain_req    <= acc_wr && (req_addr == OFF_PRIM) && (req_wdata == PRIM_DRAIN);
      pf_flush_req <= acc_wr && (req_addr == OFF_PRIM) && (req_wdata == PRIM_PFFLUSH);
      if (acc_wr && req_addr == OFF_PRIM) prim_q <= req_wdata[3:0];
    end
  end

  always_comb begin
    rsp_rdata = '0;
    unique case (req_addr)
      OFF_MODE: rsp_rdata = mode_q;
      OFF_ADDR: rsp_rdata = 32'(addr_q);
      OFF_SIZE: rsp_rdata = 32'(size_q);
      OFF_SCE:  rsp_rdata = {30'd0, sce_rdata};
      OFF_QST:  rsp_rdata = {29'd0, ef_q[req_cpu], busy && (run_cpu == req_cpu), pend_nz[req_cpu]};
      OFF_PRIM: rsp_rdata = {28'd0, prim_q};
      default:  rsp_rdata = '0;
    endcase
  end

  assert_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (prim_rd_req && cmd_valid) |-> !req_ready);
  assert_prim_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({drain_req, pf_flush_req}));

endmodule

// File: tb/cmq_frontend_test.sv
`timescale 1ns/100ps
module cmq_frontend_test;
  localparam int NCPU = 4;
  localparam int AW = 32;
  localparam int QD = 4;
  localparam int CW = $clog2(NCPU);

  localparam logic [11:0] A_PRIM = 12'h244, A_MODE = 12'h248, A_ADDR = 12'h24C,
                          A_SIZE = 12'h250, A_SCE = 12'h25C, A_QST = 12'h260;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [CW-1:0] req_cpu = '0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready;
  logic [31:0] rsp_rdata;
  logic cmd_valid, cmd_ready = 1'b0, cmd_notify;
  logic [1:0] cmd_scope;
  logic [3:0] cmd_op;
  logic [AW-1:0] cmd_addr, cmd_size;
  logic [CW-1:0] cmd_cpu;
  logic op_done = 1'b0;
  logic drain_req, pf_flush_req;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  cmq_frontend #(.NCPU(NCPU), .AW(AW), .QDEPTH(QD)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_cpu(req_cpu), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_rdata(rsp_rdata), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_scope(cmd_scope), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_size(cmd_size), .cmd_cpu(cmd_cpu),
    .cmd_notify(cmd_notify), .op_done(op_done), .drain_req(drain_req),
    .pf_flush_req(pf_flush_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input int cpu, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_cpu = CW'(cpu); req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(input int cpu, input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_cpu = CW'(cpu); req_addr = a;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    d = rsp_rdata;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic rd_check(input string tag, input int cpu, input logic [11:0] a,
                          input logic [31:0] exp);
    logic [31:0] v;
    bus_rd(cpu, a, v);
    check(tag, v, exp);
  endtask

  // executor side: take one entry, checking its fields
  task automatic run_one(input string tag, input int scope, input int op, input int ntf,
                         input int cpu, input logic [31:0] addr, input logic [31:0] size);
    @(negedge clk);
    while (!cmd_valid) @(negedge clk);
    check({tag, " scope"}, 32'(cmd_scope), 32'(scope));
    check({tag, " op"}, 32'(cmd_op), 32'(op));
    check({tag, " notify"}, 32'(cmd_notify), 32'(ntf));
    check({tag, " cpu"}, 32'(cmd_cpu), 32'(cpu));
    check({tag, " addr"}, 32'(cmd_addr), addr);
    check({tag, " size"}, 32'(cmd_size), size);
    cmd_ready = 1'b1;
    @(posedge clk); #1;
    cmd_ready = 1'b0;
  endtask

  task automatic finish_one();
    @(negedge clk);
    op_done = 1'b1;
    @(posedge clk); #1;
    op_done = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 cmd_valid", 32'(cmd_valid), 0);
    check("R1 req_ready", 32'(req_ready), 1);
    rd_check("R1 qstat", 0, A_QST, 0);
    rd_check("R1 setstat", 1, A_SCE, 0);
    rd_check("R1 prim", 2, A_PRIM, 0);
  endtask

  task automatic t_lock();
    bus_wr(0, A_MODE, 32'h2);
    bus_wr(1, A_MODE, 32'h0002_0001);
    bus_wr(1, A_ADDR, 32'hDEAD);
    rd_check("R2 mode kept", 2, A_MODE, 32'h2);
    rd_check("R2 addr kept", 3, A_ADDR, 32'h0);
    rd_check("R2 R6 foreign fail", 1, A_SCE, 32'h1);
    rd_check("R6 cleared", 1, A_SCE, 32'h0);
    rd_check("R6 per cpu", 3, A_SCE, 32'h0);
    bus_wr(0, A_ADDR, 32'h1000);
    bus_wr(0, A_SIZE, 32'h40);
    rd_check("R4 range ok", 0, A_SCE, 32'h0);
    @(negedge clk);
    check("R4 queued", 32'(cmd_valid), 1);
    bus_wr(1, A_MODE, 32'h0002_0000);
    rd_check("R3 reacquire", 1, A_SCE, 32'h0);
  endtask

  task automatic t_order();
    logic [31:0] v;
    run_one("R7 first", 0, 2, 0, 0, 32'h1000, 32'h40);
    @(negedge clk);
    check("R7 hold next", 32'(cmd_valid), 0);
    rd_check("R9 exec cpu0", 0, A_QST, 32'h3);
    rd_check("R9 pend cpu1", 1, A_QST, 32'h1);
    finish_one();
    run_one("R7 second", 1, 0, 0, 1, 32'h0, 32'h0);
    finish_one();
    bus_rd(1, A_QST, v);
    check("R9 idle cpu1", v, 32'h0);
  endtask

  task automatic t_incomplete();
    bus_wr(2, A_MODE, 32'h1);
    bus_wr(2, A_SIZE, 32'h40);
    rd_check("R4 incomplete", 2, A_SCE, 32'h1);
    @(negedge clk);
    check("R4 nothing queued", 32'(cmd_valid), 0);
    rd_check("R4 qstat cpu2", 2, A_QST, 32'h0);
    bus_wr(3, A_MODE, 32'h0002_0002);
    rd_check("R3 after fail", 3, A_SCE, 32'h0);
    run_one("R4 all", 1, 2, 0, 3, 32'h0, 32'h0);
    finish_one();
  endtask

  task automatic t_full();
    for (int i = 0; i < QD; i++) begin
      bus_wr(0, A_MODE, 32'h0002_0000 | 32'(i));
      rd_check("R5 fill", 0, A_SCE, 32'h0);
    end
    bus_wr(0, A_MODE, 32'h0002_0001);
    rd_check("R5 full", 0, A_SCE, 32'h2);
    bus_wr(1, A_MODE, 32'h0002_0001);
    rd_check("R5 R3 full other", 1, A_SCE, 32'h2);
    rd_check("R9 pend cpu0", 0, A_QST, 32'h1);
    rd_check("R5 none cpu1", 1, A_QST, 32'h0);
    for (int i = 0; i < QD; i++) begin
      run_one("R7 drain", 1, i, 0, 0, 32'h0, 32'h0);
      finish_one();
    end
  endtask

  task automatic t_endflag();
    bus_wr(2, A_MODE, 32'h0000_8001);
    bus_wr(2, A_ADDR, 32'h2000);
    bus_wr(2, A_SIZE, 32'h80);
    rd_check("R4 notify entry", 2, A_SCE, 32'h0);
    bus_wr(3, A_MODE, 32'h0002_0000);
    rd_check("R4 second", 3, A_SCE, 32'h0);
    run_one("R8 notify cmd", 0, 1, 1, 2, 32'h2000, 32'h80);
    rd_check("R9 exec cpu2", 2, A_QST, 32'h3);
    finish_one();
    rd_check("R8 flag set", 2, A_QST, 32'h4);
    rd_check("R9 waiting cpu3", 3, A_QST, 32'h1);
    bus_wr(2, A_QST, 32'h0);
    rd_check("R8 zero write", 2, A_QST, 32'h4);
    bus_wr(3, A_QST, 32'h4);
    rd_check("R8 other cpu write", 2, A_QST, 32'h4);
    bus_wr(2, A_QST, 32'h4);
    rd_check("R8 cleared", 2, A_QST, 32'h0);
    run_one("R8 plain cmd", 1, 0, 0, 3, 32'h0, 32'h0);
    finish_one();
    rd_check("R8 no notify", 3, A_QST, 32'h0);
  endtask

  task automatic t_prim();
    bus_wr(0, A_PRIM, 32'h8);
    check("R10 drain pulse", {30'd0, drain_req, pf_flush_req}, 32'h2);
    @(posedge clk); #1;
    check("R10 drain one cycle", 32'(drain_req), 0);
    bus_wr(1, A_PRIM, 32'h9);
    check("R10 pf pulse", {30'd0, drain_req, pf_flush_req}, 32'h1);
    bus_wr(2, A_PRIM, 32'h3);
    check("R10 other code", {30'd0, drain_req, pf_flush_req}, 32'h0);
    rd_check("R10 readback", 3, A_PRIM, 32'h3);
  endtask

  task automatic t_stall();
    logic [31:0] v;
    bit rd_done;
    rd_done = 1'b0;
    bus_wr(1, A_MODE, 32'h0002_0002);
    rd_check("R11 setup", 1, A_SCE, 32'h0);
    fork
      begin
        bus_rd(1, A_PRIM, v);
        rd_done = 1'b1;
      end
      begin
        repeat (6) @(posedge clk);
        #1;
        check("R11 wait state", {30'd0, req_ready, rd_done}, 32'h0);
        run_one("R11 cmd", 1, 2, 0, 1, 32'h0, 32'h0);
        repeat (3) @(posedge clk);
        #1;
        check("R11 still busy", 32'(rd_done), 0);
        finish_one();
        repeat (3) @(posedge clk);
        #1;
        check("R11 released", 32'(rd_done), 1);
      end
    join
    check("R11 data", v, 32'h3);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_lock();
    t_order();
    t_incomplete();
    t_full();
    t_endflag();
    t_prim();
    t_stall();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule